// File: doc/BRIEF.md
# Mesh Router with Input-Buffer Bypass

This block is one node of a two-dimensional packet-switched mesh. It has five input ports and five output ports: one toward the local tile and one toward each of the four neighbours. Packets are split into flits. Every flit carries head and tail flags, a hub flag and a destination coordinate pair. The router resolves the X offset first and the Y offset second. A round-robin switch allocator sits on each output, and a crossbar sends the winning flit into a registered link stage.

Each input has a small FIFO, but a flit only enters it when it cannot leave at once. If the input's buffer is empty, the chosen output is free, the downstream node has a credit, and the flit wins allocation, the flit skips the buffer and lands in the link register on the next edge. The FIFO is written and read only when the flit has to wait. Flow control between neighbours uses credits. The node returns a credit upstream for every flit that leaves an input, and it keeps one credit counter per output for the buffer in the next router.

A parameter adds a sixth output for one designated router in a cluster. Flits that have arrived at their destination and carry the hub flag leave on that output instead of the local one.

Top module: `mesh_bypass_router`

## Requirements
- R1: After synchronous reset, every tx_valid and rx_credit bit is low, and each output's credit count equals DN_DEPTH.
- R2: The flit layout, from the most significant bit down, is head (bit FW-1), tail (FW-2), hub flag (FW-3), destination X (CW bits), destination Y (CW bits), then DATA_W bits of payload. Output indices are local 0, north 1, south 2, east 3, west 4, hub 5. A destination X above MY_X goes east and below goes west. Only when X matches does Y decide: above MY_Y goes north and below goes south. A full match goes to local.
- R3: With HUB_EN=1 the router has a sixth output (index 5). A flit whose destination matches the router and whose hub flag is set leaves there. With HUB_EN=0 the same flit leaves on local. The hub flag has no effect on a flit that is not yet at its destination.
- R4: A flit offered in cycle n, to an empty input buffer, on a free output that has a credit, appears unchanged on that output's tx_flit with tx_valid in cycle n+1.
- R5: rx_credit for an input pulses for one cycle, in the same cycle that a flit taken from that input appears on an output.
- R6: No output sends while its credit count is zero. A credit returned on tx_credit in cycle n lets a waiting flit appear in cycle n+2.
- R7: Head flits that compete for a free output are granted in round-robin order, starting with the input after the last winner. After reset, input 0 has the highest priority.
- R8: A flit that loses allocation is held in its input buffer and is sent in a later cycle. Flits from one input leave in arrival order, and the buffer never takes a flit while it is full.
- R9: A flit that arrives at an input whose buffer is not empty is queued behind the buffered flits, even if its own output is idle.
- R10: Once a head flit without the tail flag wins an output, only that input may use the output until its tail flit has passed. Heads from other inputs wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 5 | Flit present on each input, indexed like the outputs |
| rx_flit | input | 5*FW | Input flits; input i occupies bits [i*FW +: FW] |
| rx_credit | output | 5 | One-cycle credit return to each upstream neighbour |
| tx_valid | output | NOUT | Registered flit-valid per output (NOUT = 5 + HUB_EN) |
| tx_flit | output | NOUT*FW | Registered output flits; output o occupies bits [o*FW +: FW] |
| tx_credit | input | NOUT | Credit returned by the downstream buffer of each output |

## Verification
The assertions assume that each neighbour behaves as a credit-respecting peer. No upstream node sends more flits into an input than the number of credits it holds. No downstream node returns a credit for a flit it never received. Every packet has a single head, an ordered run of body flits from one input, a closing tail, and the same destination in every flit. Without these assumptions, the overflow and credit-limit properties would say nothing about the design. The stimulus keeps within them. It issues at most a few flits per input before they drain, it returns downstream credits only one cycle after a flit is seen on an output (or through one explicit manual pulse after a withheld flit), and it builds every packet with the same flit constructor.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int NIN = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4,
    PORT_HUB   = 3'd5
  } port_e;
endpackage

// File: rtl/mbr_in_fifo.sv
module mbr_in_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  // storage written in its own process so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + (AW+1)'(1);
      if (pop)  rp <= rp + (AW+1)'(1);
    end
  end

  assign dout  = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
endmodule

// File: rtl/mbr_route.sv
module mbr_route import mbr_pkg::*; #(
  parameter int CW     = 4,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0,
  parameter int HUB_EN = 0
) (
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic          to_hub,
  output port_e         port
);
  localparam logic [CW-1:0] HOME_X = CW'(MY_X);
  localparam logic [CW-1:0] HOME_Y = CW'(MY_Y);

  // dimension order: X is settled before Y is looked at
  always_comb begin
    if (dst_x > HOME_X)                 port = PORT_EAST;
    else if (dst_x < HOME_X)            port = PORT_WEST;
    else if (dst_y > HOME_Y)            port = PORT_NORTH;
    else if (dst_y < HOME_Y)            port = PORT_SOUTH;
    else if ((HUB_EN != 0) && to_hub)   port = PORT_HUB;
    else                                port = PORT_LOCAL;
  end
endmodule

// File: rtl/mbr_out_arb.sv
module mbr_out_arb #(
  parameter int NIN      = 5,
  parameter int DN_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NIN-1:0]         req,
  input  logic [NIN-1:0]         head,
  input  logic [NIN-1:0]         tail,
  input  logic                   credit_in,
  output logic [NIN-1:0]         gnt,
  output logic                   fire,
  output logic [$clog2(NIN)-1:0] sel
);
  localparam int IW    = $clog2(NIN);
  localparam int CNT_W = $clog2(DN_DEPTH + 1);

  logic           lock_v;
  logic [IW-1:0]  owner, ptr, win;
  logic [CNT_W-1:0] cnt;
  logic [NIN-1:0] elig;
  logic           found;

  always_comb begin
    elig = '0;
    for (int i = 0; i < NIN; i++)
      elig[i] = req[i] && (lock_v ? (owner == IW'(i)) : head[i]);
    found = 1'b0;
    win   = ptr;
    for (int k = 1; k <= NIN; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NIN;
      if (!found && elig[idx]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
    gnt = '0;
    if (found && (cnt != '0)) gnt[win] = 1'b1;
  end

  assign fire = |gnt;
  assign sel  = win;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_v <= 1'b0;
      owner  <= '0;
      ptr    <= IW'(NIN - 1);
      cnt    <= CNT_W'(DN_DEPTH);
    end else begin
      cnt <= cnt + CNT_W'(credit_in) - CNT_W'(fire);
      if (fire) begin
        ptr    <= win;
        owner  <= win;
        lock_v <= !tail[win];
      end
    end
  end
endmodule

// File: rtl/mesh_bypass_router.sv
module mesh_bypass_router import mbr_pkg::*; #(
  parameter int DATA_W    = 128,
  parameter int CW        = 4,
  parameter int MY_X      = 0,
  parameter int MY_Y      = 0,
  parameter int BUF_DEPTH = 4,
  parameter int DN_DEPTH  = 4,
  parameter int HUB_EN    = 0,
  localparam int FW   = DATA_W + 3 + 2*CW,
  localparam int NOUT = NIN + ((HUB_EN != 0) ? 1 : 0)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NIN-1:0]      rx_valid,
  input  logic [NIN*FW-1:0]   rx_flit,
  output logic [NIN-1:0]      rx_credit,
  output logic [NOUT-1:0]     tx_valid,
  output logic [NOUT*FW-1:0]  tx_flit,
  input  logic [NOUT-1:0]     tx_credit
);
  localparam int IW = $clog2(NIN);

  logic [NIN-1:0]           f_empty, f_full, f_push, f_pop;
  logic [NIN-1:0]           c_valid, c_head, c_tail, gnt_in;
  logic [NIN-1:0][FW-1:0]   f_dout, c_flit;
  port_e                    c_port [NIN];
  logic [NOUT-1:0][NIN-1:0] req, gnt;
  logic [NOUT-1:0]          fire;
  logic [NOUT-1:0][IW-1:0]  sel;
  logic [NOUT-1:0][FW-1:0]  tx_q;

  for (genvar i = 0; i < NIN; i++) begin : g_in
    // candidate: oldest buffered flit, or the arriving one if nothing waits
    assign c_valid[i] = rx_valid[i] | ~f_empty[i];
    assign c_flit[i]  = f_empty[i] ? rx_flit[i*FW +: FW] : f_dout[i];
    assign c_head[i]  = c_flit[i][FW-1];
    assign c_tail[i]  = c_flit[i][FW-2];

    // write only when the arriving flit cannot go straight through
    assign f_push[i] = rx_valid[i] & ~(f_empty[i] & gnt_in[i]);
    assign f_pop[i]  = ~f_empty[i] & gnt_in[i];

    mbr_in_fifo #(.W(FW), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (f_push[i]),
      .pop  (f_pop[i]),
      .din  (rx_flit[i*FW +: FW]),
      .dout (f_dout[i]),
      .empty(f_empty[i]),
      .full (f_full[i])
    );

    mbr_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y), .HUB_EN(HUB_EN)) u_route (
      .dst_x (c_flit[i][FW-4 -: CW]),
      .dst_y (c_flit[i][FW-4-CW -: CW]),
      .to_hub(c_flit[i][FW-3]),
      .port  (c_port[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++)
      for (int i = 0; i < NIN; i++)
        req[o][i] = c_valid[i] && (c_port[i] == port_e'(o));
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    mbr_out_arb #(.NIN(NIN), .DN_DEPTH(DN_DEPTH)) u_arb (
      .clk      (clk),
      .rst      (rst),
      .req      (req[o]),
      .head     (c_head),
      .tail     (c_tail),
      .credit_in(tx_credit[o]),
      .gnt      (gnt[o]),
      .fire     (fire[o]),
      .sel      (sel[o])
    );
  end

  always_comb begin
    gnt_in = '0;
    for (int o = 0; o < NOUT; o++) gnt_in = gnt_in | gnt[o];
  end

  // crossbar into the link register
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid  <= '0;
      rx_credit <= '0;
    end else begin
      tx_valid  <= fire;
      rx_credit <= gnt_in;
    end
    for (int o = 0; o < NOUT; o++)
      if (fire[o]) tx_q[o] <= c_flit[sel[o]];
  end

  assign tx_flit = tx_q;
endmodule

// File: rtl/mesh_bypass_router_chk.sv
module mesh_bypass_router_chk #(
  parameter int NIN      = 5,
  parameter int NOUT     = 5,
  parameter int DN_DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NIN-1:0]         rx_valid,
  input logic [NIN-1:0]         rx_credit,
  input logic [NIN-1:0]         f_empty,
  input logic [NIN-1:0]         f_full,
  input logic [NIN-1:0]         f_push,
  input logic [NOUT-1:0]        tx_valid,
  input logic [NOUT-1:0]        tx_credit,
  input logic [NOUT-1:0][NIN-1:0] gnt
);
  logic [NIN-1:0][NOUT-1:0] col;
  int outst [NOUT];

  always_comb begin
    for (int i = 0; i < NIN; i++)
      for (int o = 0; o < NOUT; o++)
        col[i][o] = gnt[o][i];
  end

  // flits on the link not yet acknowledged by the downstream buffer
  always_ff @(posedge clk) begin
    for (int o = 0; o < NOUT; o++) begin
      if (rst) outst[o] <= 0;
      else     outst[o] <= outst[o] + int'(tx_valid[o]) - int'(tx_credit[o]);
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (tx_valid == '0 && rx_credit == '0));

  for (genvar i = 0; i < NIN; i++) begin : g_ci
    a_r9_no_overtake: assert property (@(posedge clk) disable iff (rst)
      (rx_valid[i] && !f_empty[i]) |-> f_push[i]);
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
      f_push[i] |-> !f_full[i]);
    a_r8_single_output: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[i]));
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_co
    a_r6_credit_limit: assert property (@(posedge clk) disable iff (rst)
      (outst[o] >= 0) && (outst[o] <= DN_DEPTH));
  end
endmodule

bind mesh_bypass_router mesh_bypass_router_chk #(
  .NIN(mbr_pkg::NIN), .NOUT(NOUT), .DN_DEPTH(DN_DEPTH)
) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_credit(rx_credit),
  .f_empty(f_empty), .f_full(f_full), .f_push(f_push),
  .tx_valid(tx_valid), .tx_credit(tx_credit), .gnt(gnt)
);

// File: tb/mesh_bypass_router_tb_top.sv
module mesh_bypass_router_tb_top;
  localparam int DW = 16, CW = 2, FW = DW + 3 + 2*CW;
  localparam int NIN = 5, NOUT = 6, NOUT0 = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst;
  logic [NIN-1:0]      rx_valid;
  logic [NIN*FW-1:0]   rx_flit;
  logic [NIN-1:0]      rx_credit, nh_rx_credit;
  logic [NOUT-1:0]     tx_valid, tx_credit, auto_q, man_credit, cred_mask;
  logic [NOUT*FW-1:0]  tx_flit;
  logic [NOUT0-1:0]    nh_tx_valid, nh_tx_credit;
  logic [NOUT0*FW-1:0] nh_tx_flit;
  int checks = 0, errors = 0;
  bit done = 0;

  assign tx_credit = auto_q | man_credit;

  mesh_bypass_router #(.DATA_W(DW), .CW(CW), .MY_X(1), .MY_Y(1),
    .BUF_DEPTH(4), .DN_DEPTH(4), .HUB_EN(1)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_flit(rx_flit),
    .rx_credit(rx_credit), .tx_valid(tx_valid), .tx_flit(tx_flit),
    .tx_credit(tx_credit));

  mesh_bypass_router #(.DATA_W(DW), .CW(CW), .MY_X(1), .MY_Y(1),
    .BUF_DEPTH(4), .DN_DEPTH(4), .HUB_EN(0)) dut_nohub_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_flit(rx_flit),
    .rx_credit(nh_rx_credit), .tx_valid(nh_tx_valid), .tx_flit(nh_tx_flit),
    .tx_credit(nh_tx_credit));

  // downstream model: one credit back per flit seen, unless masked
  initial begin
    auto_q = '0;
    nh_tx_credit = '0;
    forever begin
      @(posedge clk);
      #1;
      auto_q       = tx_valid & cred_mask;
      nh_tx_credit = nh_tx_valid;
    end
  end

  function automatic logic [FW-1:0] mk(bit h, bit t, bit hub, int x, int y, int d);
    return {h, t, hub, 2'(x), 2'(y), 16'(d)};
  endfunction

  function automatic logic [FW-1:0] outf(int o);
    return tx_flit[o*FW +: FW];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input int p, input logic [FW-1:0] f);
    rx_valid[p] = 1'b1;
    rx_flit[p*FW +: FW] = f;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rx_valid = '0;
    man_credit = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx_valid idle", 64'(tx_valid), 64'(0));
    chk("R1 rx_credit idle", 64'(rx_credit), 64'(0));
    chk("R1 nohub tx idle", 64'(nh_tx_valid), 64'(0));
  endtask

  task automatic t_route();
    int xs[7] = '{2, 0, 1, 1, 1, 2, 0};
    int ys[7] = '{1, 1, 2, 0, 1, 0, 3};
    int ex[7] = '{3, 4, 1, 2, 0, 3, 4};
    do_reset();
    for (int k = 0; k < 7; k++) begin
      int ip;
      logic [FW-1:0] f;
      ip = k % NIN;
      f = mk(1, 1, 0, xs[k], ys[k], 16'h100 + k);
      @(negedge clk);
      send(ip, f);
      @(negedge clk);
      rx_valid = '0;
      chk("R2 output port", 64'(tx_valid), 64'(1) << ex[k]);
      chk("R4 bypass flit", 64'(outf(ex[k])), 64'(f));
      chk("R5 credit return", 64'(rx_credit), 64'(1) << ip);
    end
  endtask

  task automatic t_hub();
    logic [FW-1:0] f1, f2;
    do_reset();
    f1 = mk(1, 1, 1, 1, 1, 16'h0A0B);
    f2 = mk(1, 1, 1, 2, 1, 16'h0C0D);
    @(negedge clk);
    send(1, f1);
    @(negedge clk);
    rx_valid = '0;
    chk("R3 hub port used", 64'(tx_valid), 64'h20);
    chk("R3 hub flit", 64'(outf(5)), 64'(f1));
    chk("R3 no-hub variant to local", 64'(nh_tx_valid), 64'h01);
    chk("R3 no-hub flit", 64'(nh_tx_flit[0 +: FW]), 64'(f1));
    send(1, f2);
    @(negedge clk);
    rx_valid = '0;
    chk("R3 hub flag ignored in transit", 64'(tx_valid), 64'h08);
    chk("R3 no-hub in transit", 64'(nh_tx_valid), 64'h08);
  endtask

  task automatic t_rr();
    logic [FW-1:0] a, b, c, d;
    do_reset();
    a = mk(1, 1, 0, 2, 1, 16'h00A1);
    b = mk(1, 1, 0, 2, 1, 16'h00B2);
    c = mk(1, 1, 0, 2, 1, 16'h00C3);
    d = mk(1, 1, 0, 2, 1, 16'h00D4);
    @(negedge clk);
    send(1, a);
    send(2, b);
    @(negedge clk);
    rx_valid = '0;
    chk("R7 first winner lower input", 64'(outf(3)), 64'(a));
    chk("R8 loser holds credit", 64'(rx_credit), 64'h02);
    @(negedge clk);
    chk("R8 buffered flit sent later", 64'(outf(3)), 64'(b));
    chk("R8 buffered credit", 64'(rx_credit), 64'h04);
    send(2, c);
    send(4, d);
    @(negedge clk);
    rx_valid = '0;
    chk("R7 rotated priority", 64'(outf(3)), 64'(d));
    @(negedge clk);
    chk("R7 second after rotation", 64'(outf(3)), 64'(c));
  endtask

  task automatic t_overtake();
    logic [FW-1:0] a, b, c;
    do_reset();
    a = mk(1, 1, 0, 2, 1, 16'h1111);
    b = mk(1, 1, 0, 2, 1, 16'h2222);
    c = mk(1, 1, 0, 1, 1, 16'h3333);
    @(negedge clk);
    send(1, a);
    send(2, b);
    @(negedge clk);
    rx_valid = '0;
    send(2, c);
    chk("R9 first east flit", 64'(tx_valid), 64'h08);
    @(negedge clk);
    rx_valid = '0;
    chk("R9 queued flit first, local idle", 64'(tx_valid), 64'h08);
    chk("R9 queued flit data", 64'(outf(3)), 64'(b));
    @(negedge clk);
    chk("R9 later flit after queue", 64'(tx_valid), 64'h01);
    chk("R9 later flit data", 64'(outf(0)), 64'(c));
  endtask

  task automatic t_hold();
    logic [FW-1:0] h, bd, t, x;
    do_reset();
    h  = mk(1, 0, 0, 2, 1, 16'h4001);
    bd = mk(0, 0, 0, 2, 1, 16'h4002);
    t  = mk(0, 1, 0, 2, 1, 16'h4003);
    x  = mk(1, 1, 0, 2, 1, 16'h5001);
    @(negedge clk);
    send(1, h);
    @(negedge clk);
    rx_valid = '0;
    chk("R10 head out", 64'(outf(3)), 64'(h));
    send(1, bd);
    send(4, x);
    @(negedge clk);
    rx_valid = '0;
    chk("R10 body keeps output", 64'(outf(3)), 64'(bd));
    send(1, t);
    @(negedge clk);
    rx_valid = '0;
    chk("R10 tail keeps output", 64'(outf(3)), 64'(t));
    @(negedge clk);
    chk("R10 waiting head after tail", 64'(outf(3)), 64'(x));
    chk("R10 waiting head credit", 64'(rx_credit), 64'h10);
  endtask

  task automatic t_backpressure();
    logic [FW-1:0] f [5];
    do_reset();
    cred_mask = 6'b110111;
    for (int k = 0; k < 5; k++) f[k] = mk(1, 1, 0, 3, 0, 16'h6000 + k);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      rx_valid = '0;
      if (k > 0) chk("R1 R6 credited send", 64'(outf(3)), 64'(f[k-1]));
      send(0, f[k]);
    end
    @(negedge clk);
    rx_valid = '0;
    chk("R1 R6 fourth credit used", 64'(outf(3)), 64'(f[3]));
    man_credit[3] = 1'b1;
    @(negedge clk);
    man_credit = '0;
    chk("R6 no send without credit", 64'(tx_valid[3]), 64'(0));
    @(negedge clk);
    chk("R6 send after credit", 64'(tx_valid[3]), 64'(1));
    chk("R6 held flit data", 64'(outf(3)), 64'(f[4]));
    chk("R6 credit back upstream", 64'(rx_credit), 64'h01);
    cred_mask = '1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    rx_valid = '0;
    rx_flit = '0;
    man_credit = '0;
    cred_mask = '1;
    t_reset();
    t_route();
    t_hub();
    t_rr();
    t_overtake();
    t_hold();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule